// File: doc/BRIEF.md
# Mainboard Power and Interrupt Register Bank

This block holds the mainboard controller's word-wide registers for RAM size, slot interrupt status, slot power, global interrupt enable, the CPU-present mask, CPU run enables and CPU self-identification. Software reaches them through a single-cycle word request port. A read returns its data one clock later with a valid flag. A write takes effect at the clock edge that accepts it. The byte offset is given within the controller's configuration region.

The block receives the per-slot IRQ lines, the mask of occupied slots, the probed RAM size, the CPU-present mask and the number of the CPU making each request. It drives the slot power enables and the CPU run enables. It also drives the interrupt vector after the global enable has masked it, and that vector feeds the downstream routing logic.

Each register has its own semantics. The RAM size and the CPU-present mask are read-only copies of their inputs. Interrupt status is a live view of the IRQ lines. Slot power is loaded from the occupied-slot mask at reset. Self-identification answers differently depending on which CPU asks.

Top module: `board_ctl_regs`

## Requirements
- R1: A read at byte offset 0x200 returns `ramBytes`. A write there is accepted silently and changes no register or output.
- R2: A read at 0x204 returns the current `irqLines`, including bit 31, which is the controller's own slot. A write there has no effect.
- R3: While `rstN` is low at a clock edge, the power mask loads `slotPresent`, and `slotPowerEn` shows that value after the edge.
- R4: A write at 0x208 with bit 31 set replaces the power mask with the written word. `slotPowerEn` and later reads at 0x208 show the new mask from the next cycle on.
- R5: A write at 0x208 with bit 31 clear turns every slot off in that same update, whatever the other written bits are.
- R6: The global interrupt enable at 0x20C resets to 0xFFFFFFFF. A write there replaces it, and a read returns it.
- R7: `irqGated` bit N is set exactly when `irqLines` bit N and enable bit N are both set. A slot that is masked this way still reads as set at 0x204.
- R8: A read at 0x210 returns `cpuPresent`, which may be a non-contiguous mask. A write there has no effect.
- R9: The CPU run mask at 0x214 resets to only bit 0 (the boot CPU). A write there replaces it and drives `cpuRunEn` from the next cycle.
- R10: A read at 0x218 returns a word with only bit `reqCpu` set.
- R11: Only the bits above bit 1 of `reqAddr` select a word. A read sets `rdValid` for exactly the following cycle, and a write leaves `rdValid` low. A read at any offset not listed above returns 0, and a write to such an offset changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W (10) | Byte offset within the configuration region |
| reqWdata | input | 32 | Write data |
| reqCpu | input | CPU_ID_W (5) | Number of the requesting CPU |
| irqLines | input | SLOTS (32) | Per-slot IRQ lines |
| slotPresent | input | SLOTS (32) | Occupied-slot mask, loaded into power at reset |
| ramBytes | input | 32 | Probed RAM size in bytes |
| cpuPresent | input | CPUS (32) | CPU-present mask |
| slotPowerEn | output | SLOTS (32) | Slot power enables |
| cpuRunEn | output | CPUS (32) | CPU run enables |
| irqGated | output | SLOTS (32) | IRQ lines after the global enable mask |
| rdData | output | 32 | Read data, one cycle after the request |
| rdValid | output | 1 | Read data valid |

## Verification
Two things can decide the power mask in the same update: the explicit power-on bits of a write, and the mainboard power-off rule. The bench provokes this by writing 0x7FFFFFFF, which has every slot bit set except the mainboard bit. It then judges `slotPowerEn` and a read-back at 0x208, both of which must be all zero. A second case combines a masking write to the enable register with interrupt lines that are already asserted. In the following cycle the gated vector must drop the masked bits, while a read of the live status still shows them.

// File: rtl/board_ctl_pkg.sv
package board_ctl_pkg;

  localparam int WORD_W = 32;

  // Word indexes (byte offset >> 2) of the register bank
  localparam int WIDX_RAM  = 'h80;
  localparam int WIDX_IRQ  = 'h81;
  localparam int WIDX_PWR  = 'h82;
  localparam int WIDX_IEN  = 'h83;
  localparam int WIDX_CPUP = 'h84;
  localparam int WIDX_CPUE = 'h85;
  localparam int WIDX_SELF = 'h86;

  typedef enum logic [2:0] {
    SEL_RAM, SEL_IRQ, SEL_PWR, SEL_IEN, SEL_CPUP, SEL_CPUE, SEL_SELF, SEL_NONE
  } regSel_e;

  typedef struct packed {
    logic    wrPwr;
    logic    wrIrqEn;
    logic    wrCpuEn;
    logic    rdEn;
    regSel_e rdSel;
  } ctlStrobes_t;

endpackage

// File: rtl/board_ctl_decode.sv
module board_ctl_decode
  import board_ctl_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output ctlStrobes_t       strobes
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  logic             unusedByteBits;
  regSel_e          sel;

  assign wordIdx        = reqAddr[ADDR_W-1:2];
  assign unusedByteBits = ^reqAddr[1:0];

  always_comb begin
    sel = SEL_NONE;
    case (wordIdx)
      IDX_W'(WIDX_RAM):  sel = SEL_RAM;
      IDX_W'(WIDX_IRQ):  sel = SEL_IRQ;
      IDX_W'(WIDX_PWR):  sel = SEL_PWR;
      IDX_W'(WIDX_IEN):  sel = SEL_IEN;
      IDX_W'(WIDX_CPUP): sel = SEL_CPUP;
      IDX_W'(WIDX_CPUE): sel = SEL_CPUE;
      IDX_W'(WIDX_SELF): sel = SEL_SELF;
      default:           sel = SEL_NONE;
    endcase
  end

  always_comb begin
    strobes.wrPwr   = reqValid && reqWrite && (sel == SEL_PWR);
    strobes.wrIrqEn = reqValid && reqWrite && (sel == SEL_IEN);
    strobes.wrCpuEn = reqValid && reqWrite && (sel == SEL_CPUE);
    strobes.rdEn    = reqValid && !reqWrite;
    strobes.rdSel   = sel;
  end

endmodule

// File: rtl/board_ctl_datapath.sv
module board_ctl_datapath
  import board_ctl_pkg::*;
#(
  parameter int SLOTS    = 32,
  parameter int CPUS     = 32,
  parameter int BOOT_CPU = 0,
  parameter int CPU_ID_W = $clog2(CPUS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobes_t         strobes,
  input  logic [WORD_W-1:0]   reqWdata,
  input  logic [CPU_ID_W-1:0] reqCpu,
  input  logic [SLOTS-1:0]    irqLines,
  input  logic [SLOTS-1:0]    slotPresent,
  input  logic [WORD_W-1:0]   ramBytes,
  input  logic [CPUS-1:0]     cpuPresent,
  output logic [SLOTS-1:0]    slotPowerEn,
  output logic [CPUS-1:0]     cpuRunEn,
  output logic [SLOTS-1:0]    irqGated,
  output logic [WORD_W-1:0]   rdData,
  output logic                rdValid
);

  localparam int BOARD_SLOT = SLOTS - 1;
  localparam logic [CPUS-1:0] CPU_BOOT_MASK = CPUS'(1) << BOOT_CPU;

  logic [SLOTS-1:0]  pwrMask;
  logic [SLOTS-1:0]  irqEnMask;
  logic [CPUS-1:0]   cpuEnMask;
  logic [SLOTS-1:0]  pwrNext;
  logic [WORD_W-1:0] selfWord;
  logic [WORD_W-1:0] rdMux;

  // Power update: clearing the mainboard bit drops every slot at once
  always_comb begin
    if (!reqWdata[BOARD_SLOT]) pwrNext = '0;
    else                       pwrNext = reqWdata[SLOTS-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwrMask   <= slotPresent;
      irqEnMask <= '1;
      cpuEnMask <= CPU_BOOT_MASK;
    end else begin
      if (strobes.wrPwr)   pwrMask   <= pwrNext;
      if (strobes.wrIrqEn) irqEnMask <= reqWdata[SLOTS-1:0];
      if (strobes.wrCpuEn) cpuEnMask <= reqWdata[CPUS-1:0];
    end
  end

  // Per-slot interrupt gating
  for (genvar s = 0; s < SLOTS; s++) begin : gIrqGate
    assign irqGated[s] = irqLines[s] & irqEnMask[s];
  end

  assign selfWord = WORD_W'(1) << reqCpu;

  always_comb begin
    case (strobes.rdSel)
      SEL_RAM:  rdMux = ramBytes;
      SEL_IRQ:  rdMux = WORD_W'(irqLines);
      SEL_PWR:  rdMux = WORD_W'(pwrMask);
      SEL_IEN:  rdMux = WORD_W'(irqEnMask);
      SEL_CPUP: rdMux = WORD_W'(cpuPresent);
      SEL_CPUE: rdMux = WORD_W'(cpuEnMask);
      SEL_SELF: rdMux = selfWord;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= strobes.rdEn;
      if (strobes.rdEn) rdData <= rdMux;
    end
  end

  assign slotPowerEn = pwrMask;
  assign cpuRunEn    = cpuEnMask;

endmodule

// File: rtl/board_ctl_regs.sv
module board_ctl_regs
  import board_ctl_pkg::*;
#(
  parameter int SLOTS    = 32,
  parameter int CPUS     = 32,
  parameter int BOOT_CPU = 0,
  parameter int ADDR_W   = 10,
  parameter int CPU_ID_W = $clog2(CPUS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [31:0]         reqWdata,
  input  logic [CPU_ID_W-1:0] reqCpu,
  input  logic [SLOTS-1:0]    irqLines,
  input  logic [SLOTS-1:0]    slotPresent,
  input  logic [31:0]         ramBytes,
  input  logic [CPUS-1:0]     cpuPresent,
  output logic [SLOTS-1:0]    slotPowerEn,
  output logic [CPUS-1:0]     cpuRunEn,
  output logic [SLOTS-1:0]    irqGated,
  output logic [31:0]         rdData,
  output logic                rdValid
);

  ctlStrobes_t strobes;

  board_ctl_decode #(.ADDR_W(ADDR_W)) uDecode (
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .reqAddr  (reqAddr),
    .strobes  (strobes)
  );

  board_ctl_datapath #(
    .SLOTS    (SLOTS),
    .CPUS     (CPUS),
    .BOOT_CPU (BOOT_CPU),
    .CPU_ID_W (CPU_ID_W)
  ) uDatapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .reqWdata    (reqWdata),
    .reqCpu      (reqCpu),
    .irqLines    (irqLines),
    .slotPresent (slotPresent),
    .ramBytes    (ramBytes),
    .cpuPresent  (cpuPresent),
    .slotPowerEn (slotPowerEn),
    .cpuRunEn    (cpuRunEn),
    .irqGated    (irqGated),
    .rdData      (rdData),
    .rdValid     (rdValid)
  );

endmodule

// File: rtl/board_ctl_checker.sv
module board_ctl_checker #(
  parameter int SLOTS    = 32,
  parameter int CPUS     = 32,
  parameter int ADDR_W   = 10,
  parameter int CPU_ID_W = $clog2(CPUS)
) (
  input logic                clk,
  input logic                rstN,
  input logic                reqValid,
  input logic                reqWrite,
  input logic [ADDR_W-1:0]   reqAddr,
  input logic [31:0]         reqWdata,
  input logic [CPU_ID_W-1:0] reqCpu,
  input logic [SLOTS-1:0]    irqLines,
  input logic [SLOTS-1:0]    slotPowerEn,
  input logic [CPUS-1:0]     cpuRunEn,
  input logic [SLOTS-1:0]    irqGated,
  input logic [31:0]         rdData,
  input logic                rdValid
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic isRd, isWr, wrPwr, wrIen, wrCpue, rdSelf, wrRo;
  logic unusedCpuBits;

  assign idx    = reqAddr[ADDR_W-1:2];
  assign isRd   = reqValid && !reqWrite;
  assign isWr   = reqValid && reqWrite;
  assign wrPwr  = isWr && (idx == IDX_W'('h82));
  assign wrIen  = isWr && (idx == IDX_W'('h83));
  assign wrCpue = isWr && (idx == IDX_W'('h85));
  assign rdSelf = isRd && (idx == IDX_W'('h86));
  assign wrRo   = isWr && ((idx == IDX_W'('h80)) || (idx == IDX_W'('h81)) ||
                           (idx == IDX_W'('h84)));
  assign unusedCpuBits = ^reqCpu;

  assert_board_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrPwr && !reqWdata[SLOTS-1]) |=> (slotPowerEn == '0));

  assert_power_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrPwr && reqWdata[SLOTS-1]) |=> (slotPowerEn == $past(reqWdata[SLOTS-1:0])));

  assert_gate_subset_R7: assert property (@(posedge clk) disable iff (!rstN)
    ((irqGated & ~irqLines) == '0));

  assert_enable_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrIen |=> (irqGated == (irqLines & $past(reqWdata[SLOTS-1:0]))));

  assert_cpu_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    wrCpue |=> (cpuRunEn == $past(reqWdata[CPUS-1:0])));

  assert_self_onehot_R10: assert property (@(posedge clk) disable iff (!rstN)
    rdSelf |=> ($countones(rdData) == 1));

  assert_read_valid_R11: assert property (@(posedge clk) disable iff (!rstN)
    isRd |=> rdValid);

  assert_no_read_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !isRd |=> !rdValid);

  assert_readonly_write_R1: assert property (@(posedge clk) disable iff (!rstN)
    wrRo |=> ($stable(slotPowerEn) && $stable(cpuRunEn)));

endmodule

bind board_ctl_regs board_ctl_checker #(
  .SLOTS    (SLOTS),
  .CPUS     (CPUS),
  .ADDR_W   (ADDR_W),
  .CPU_ID_W (CPU_ID_W)
) uChk (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .reqWrite    (reqWrite),
  .reqAddr     (reqAddr),
  .reqWdata    (reqWdata),
  .reqCpu      (reqCpu),
  .irqLines    (irqLines),
  .slotPowerEn (slotPowerEn),
  .cpuRunEn    (cpuRunEn),
  .irqGated    (irqGated),
  .rdData      (rdData),
  .rdValid     (rdValid)
);

// File: tb/tb_board_ctl_regs.sv
`timescale 1ns/1ps
module tb_board_ctl_regs;

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic        reqWrite;
  logic [9:0]  reqAddr;
  logic [31:0] reqWdata;
  logic [4:0]  reqCpu;
  logic [31:0] irqLines;
  logic [31:0] slotPresent;
  logic [31:0] ramBytes;
  logic [31:0] cpuPresent;
  logic [31:0] slotPowerEn;
  logic [31:0] cpuRunEn;
  logic [31:0] irqGated;
  logic [31:0] rdData;
  logic        rdValid;

  int checks = 0;
  int errors = 0;
  logic [31:0] rd;

  always #2.5 clk = ~clk;

  board_ctl_regs dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqCpu(reqCpu),
    .irqLines(irqLines), .slotPresent(slotPresent), .ramBytes(ramBytes),
    .cpuPresent(cpuPresent), .slotPowerEn(slotPowerEn), .cpuRunEn(cpuRunEn),
    .irqGated(irqGated), .rdData(rdData), .rdValid(rdValid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [9:0] addr, input logic [31:0] data);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = addr; reqWdata = data;
    @(posedge clk); #1;
    check("R11 write leaves rdValid low", 32'(rdValid), 32'h0);
    @(negedge clk);
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic doRead(input logic [9:0] addr, input logic [4:0] cpu, output logic [31:0] data);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = addr; reqCpu = cpu;
    @(posedge clk); #1;
    data = rdData;
    check("R11 read sets rdValid", 32'(rdValid), 32'h1);
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    @(posedge clk); #1;
    check("R11 rdValid lasts one cycle", 32'(rdValid), 32'h0);
  endtask

  task automatic testReset();
    @(posedge clk); #1;
    check("R3 power loaded from present mask", slotPowerEn, 32'h8000_0025);
    check("R9 only boot CPU runs", cpuRunEn, 32'h0000_0001);
    doRead(10'h20C, 5'd0, rd);
    check("R6 enable resets to all ones", rd, 32'hFFFF_FFFF);
  endtask

  task automatic testRamSize();
    doRead(10'h200, 5'd0, rd);
    check("R1 RAM size read", rd, 32'h0100_0000);
    doWrite(10'h200, 32'h0000_0000);
    doRead(10'h200, 5'd0, rd);
    check("R1 RAM size unchanged by write", rd, 32'h0100_0000);
    check("R1 power untouched by rejected write", slotPowerEn, 32'h8000_0025);
  endtask

  task automatic testIrqStatus();
    irqLines = 32'h8000_0012;
    doRead(10'h204, 5'd0, rd);
    check("R2 live IRQ status incl bit 31", rd, 32'h8000_0012);
    doWrite(10'h204, 32'h0000_0000);
    doRead(10'h204, 5'd0, rd);
    check("R2 status write ignored", rd, 32'h8000_0012);
    check("R7 gated with full enable", irqGated, 32'h8000_0012);
  endtask

  task automatic testIrqMask();
    doWrite(10'h20C, 32'h0000_0010);
    check("R7 masked slots drop from gated vector", irqGated, 32'h0000_0010);
    doRead(10'h20C, 5'd0, rd);
    check("R6 enable read-back", rd, 32'h0000_0010);
    doRead(10'h204, 5'd0, rd);
    check("R7 masked slot still in status", rd, 32'h8000_0012);
    irqLines = 32'h0000_0000;
    #1;
    check("R7 gated follows lines", irqGated, 32'h0000_0000);
  endtask

  task automatic testPower();
    doWrite(10'h208, 32'h8000_0003);
    check("R4 power write drives enables", slotPowerEn, 32'h8000_0003);
    doRead(10'h209, 5'd0, rd);
    check("R4 power read-back (low addr bits ignored, R11)", rd, 32'h8000_0003);
  endtask

  task automatic testBoardOff();
    doWrite(10'h208, 32'h7FFF_FFFF);
    check("R5 board off clears all slots", slotPowerEn, 32'h0000_0000);
    doRead(10'h208, 5'd0, rd);
    check("R5 power reads zero after board off", rd, 32'h0000_0000);
    doWrite(10'h208, 32'h8000_0001);
    check("R4 power restored", slotPowerEn, 32'h8000_0001);
  endtask

  task automatic testCpus();
    doRead(10'h210, 5'd0, rd);
    check("R8 CPU present mask", rd, 32'h0001_0001);
    doWrite(10'h210, 32'hFFFF_FFFF);
    doRead(10'h210, 5'd0, rd);
    check("R8 present mask write ignored", rd, 32'h0001_0001);
    check("R8 run mask untouched", cpuRunEn, 32'h0000_0001);
  endtask

  task automatic testCpuEnable();
    doWrite(10'h214, 32'h0001_0001);
    check("R9 second CPU started", cpuRunEn, 32'h0001_0001);
    doRead(10'h214, 5'd0, rd);
    check("R9 run mask read-back", rd, 32'h0001_0001);
  endtask

  task automatic testSelf();
    doRead(10'h218, 5'd0, rd);
    check("R10 self CPU 0", rd, 32'h0000_0001);
    doRead(10'h218, 5'd16, rd);
    check("R10 self CPU 16", rd, 32'h0001_0000);
    doRead(10'h218, 5'd31, rd);
    check("R10 self CPU 31", rd, 32'h8000_0000);
  endtask

  task automatic testUnmapped();
    doRead(10'h21C, 5'd0, rd);
    check("R11 unmapped 0x21C reads zero", rd, 32'h0);
    doRead(10'h100, 5'd0, rd);
    check("R11 unmapped 0x100 reads zero", rd, 32'h0);
    doWrite(10'h21C, 32'h0000_0000);
    doWrite(10'h008, 32'h0000_0000);
    check("R11 unmapped write keeps power", slotPowerEn, 32'h8000_0001);
    check("R11 unmapped write keeps run mask", cpuRunEn, 32'h0001_0001);
    doRead(10'h20C, 5'd0, rd);
    check("R11 unmapped write keeps enable", rd, 32'h0000_0010);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    rstN = 1'b0; reqValid = 1'b0; reqWrite = 1'b0; reqAddr = '0; reqWdata = '0;
    reqCpu = '0; irqLines = '0; slotPresent = 32'h8000_0025;
    ramBytes = 32'h0100_0000; cpuPresent = 32'h0001_0001;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    testReset();
    testRamSize();
    testIrqStatus();
    testIrqMask();
    testPower();
    testBoardOff();
    testCpus();
    testCpuEnable();
    testSelf();
    testUnmapped();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule